// File: doc/BRIEF.md
# Two-Lane Shift-Mask Interpolator

This block is a small register-mapped arithmetic unit with two lanes. Each lane owns an accumulator, a base register and a control word. A third base register is shared. A lane selects an input, which is either its own accumulator or the other lane's. It shifts that input right logically and keeps a bit field whose two ends come from the control word. It can then sign-extend the field. Finally it adds its base to form a lane result. A combined "full" result adds the third base to the field values of both lanes.

Software uses the unit through a single-cycle register bus. A write loads an accumulator, a base or a control word. A read can return stored state. A PEEK read returns a lane result or the full result and changes nothing. A POP read returns the same value as the PEEK at that address, and at the next clock edge it writes both lane results back into the accumulators. This makes the unit suitable for walking tables, stepping fixed-point coordinates and clamping samples. Lane 0 has a clamp mode that bounds its field between base 0 and base 1. Each lane also reports whether its shifted input has set bits above the top of its field.

Register addresses (4-bit): 0 accumulator 0, 1 accumulator 1, 2 base 0, 3 base 1, 4 base 2, 5 control 0, 6 control 1, 8 peek lane 0, 9 peek lane 1, 10 peek full, 12 pop lane 0, 13 pop lane 1, 14 pop full. Any other address reads as zero.

Control word bits: [4:0] shift amount, [9:5] field low bit, [14:10] field high bit, 15 signed, 16 cross input, 17 cross result, 18 raw add, [20:19] high-bit force, 21 clamp (lane 0 only), 22 overflow (read-only).

Top module: `interp_unit`

## Requirements
- R1: After reset every accumulator, base and control word reads zero. A write to addresses 0 to 6 stores the value, and a read of the same address returns it. For control words, only bits 21:0 are stored, and bit 22 always reads the live overflow flag.
- R2: A lane's field is its input shifted right logically by bits [4:0], then masked to the inclusive bit range from bits [9:5] (low) to bits [14:10] (high). When the high bit is below the low bit, the field is zero.
- R3: With bit 15 set, the field is sign-extended from its high bit before the base is added. The full result also uses this sign-extended field.
- R4: With bit 16 set, the lane takes the other lane's accumulator as input. This applies to the raw-add path as well.
- R5: With bit 18 set, the lane result is the unshifted, unmasked input plus the lane base. The full result still uses the shifted, masked field.
- R6: The full result is base 2 plus the fields of both lanes. Base 0 and base 1 are not part of it.
- R7: Bits [20:19] are ORed into bits 29:28 of the lane result only as the bus returns it. A POP writes the unforced result into the accumulator.
- R8: A POP read (addresses 12 to 14) returns the same value as the matching PEEK. At the next edge it loads each accumulator with its own lane result, or with the other lane's result when that lane's bit 17 is set. PEEK and other reads leave the accumulators unchanged.
- R9: With bit 21 set on lane 0, the lane 0 result is the field bounded below by base 0 and above by base 1. The comparison is signed when bit 15 is set and unsigned otherwise. On lane 1, bit 21 is not stored and has no effect.
- R10: Control bit 22 reads 1 exactly when the lane's shifted input has a 1 in any position above the field high bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |

## Verification
The following are checked on every cycle by assertions:
- a POP loads the accumulator with the result it returned;
- PEEK and plain reads never disturb the accumulators;
- an empty field (high below low) yields zero;
- a field reaching the top bit never reports overflow;
- an unsigned clamp with ordered bounds stays inside them.

Only the bench's scenarios show the rest. These are the arithmetic values for each mode combination, the order of the cross-input mux relative to the raw bypass, signed clamping, the bus-only high-bit force, the cross-result write-back and the lane 1 clamp bit being discarded.

// File: rtl/interp_pkg.sv
package interp_pkg;

   localparam int ADDR_W  = 4;
   localparam int FORCE_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      A_ACC0  = 4'd0,
      A_ACC1  = 4'd1,
      A_BASE0 = 4'd2,
      A_BASE1 = 4'd3,
      A_BASE2 = 4'd4,
      A_CTRL0 = 4'd5,
      A_CTRL1 = 4'd6,
      A_PEEK0 = 4'd8,
      A_PEEK1 = 4'd9,
      A_PEEKF = 4'd10,
      A_POP0  = 4'd12,
      A_POP1  = 4'd13,
      A_POPF  = 4'd14
   } reg_addr_e;

   // lane option bits, LSB first: sgn, cross_in, cross_res, add_raw, force_hi, clamp
   typedef struct packed {
      logic               clamp;
      logic [FORCE_W-1:0] force_hi;
      logic               add_raw;
      logic               cross_res;
      logic               cross_in;
      logic               sgn;
   } lane_flags_t;

   localparam int FLG_W = $bits(lane_flags_t);

endpackage

// File: rtl/interp_field.sv
// Shift, field extract, optional sign extension and overflow detect.
module interp_field #(
   parameter int DATA_W  = 32,
   parameter int SHIFT_W = 5
) (
   input  logic [DATA_W-1:0]  src,
   input  logic [SHIFT_W-1:0] shamt,
   input  logic [SHIFT_W-1:0] lo,
   input  logic [SHIFT_W-1:0] hi,
   input  logic               sgn,
   output logic [DATA_W-1:0]  field,
   output logic               ovf
);

   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] above;
   logic [DATA_W-1:0] masked;

   assign shifted = src >> shamt;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [SHIFT_W-1:0] POS = SHIFT_W'(i);
      assign keep[i]  = (POS >= lo) && (POS <= hi);
      assign above[i] = (POS > hi);
   end

   // an inverted range leaves keep all-zero, so masked and field are zero
   assign masked = shifted & keep;
   assign field  = (sgn && masked[hi]) ? (masked | above) : masked;
   assign ovf    = |(shifted & above);

endmodule

// File: rtl/interp_lane.sv
// One lane: input select, field unit, raw/field add, optional clamp.
module interp_lane
   import interp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SHIFT_W  = 5,
   parameter bit CLAMP_EN = 1'b0
) (
   input  logic [DATA_W-1:0]  own_acc,
   input  logic [DATA_W-1:0]  far_acc,
   input  logic [DATA_W-1:0]  base,
   input  logic [DATA_W-1:0]  hi_bound,
   input  logic [SHIFT_W-1:0] shamt,
   input  logic [SHIFT_W-1:0] lo,
   input  logic [SHIFT_W-1:0] hi,
   input  lane_flags_t        flags,
   output logic [DATA_W-1:0]  field_val,
   output logic [DATA_W-1:0]  result,
   output logic               ovf
);

   logic [DATA_W-1:0] in_sel;
   logic [DATA_W-1:0] sum_val;

   // the cross mux sits ahead of both the field path and the raw bypass
   assign in_sel = flags.cross_in ? far_acc : own_acc;

   interp_field #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_field (
      .src   (in_sel),
      .shamt (shamt),
      .lo    (lo),
      .hi    (hi),
      .sgn   (flags.sgn),
      .field (field_val),
      .ovf   (ovf)
   );

   assign sum_val = flags.add_raw ? (in_sel + base) : (field_val + base);

   if (CLAMP_EN) begin : g_clamp
      logic under, over;
      always_comb begin
         if (flags.sgn) begin
            under = $signed(field_val) < $signed(base);
            over  = $signed(field_val) > $signed(hi_bound);
         end else begin
            under = field_val < base;
            over  = field_val > hi_bound;
         end
         if (!flags.clamp) result = sum_val;
         else if (under)   result = base;
         else if (over)    result = hi_bound;
         else              result = field_val;
      end
   end else begin : g_plain
      logic unused_clamp_inputs;
      assign unused_clamp_inputs = ^{hi_bound, flags.clamp};
      assign result = sum_val;
   end

endmodule

// File: rtl/interp_unit.sv
// Two-lane interpolator with register bus, PEEK/POP results and full result.
module interp_unit
   import interp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int FORCE_LSB = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int SHIFT_W = $clog2(DATA_W);
   localparam int OFF_LO  = SHIFT_W;
   localparam int OFF_HI  = 2 * SHIFT_W;
   localparam int OFF_FLG = 3 * SHIFT_W;
   localparam int CTRL_W  = OFF_FLG + FLG_W + 1;
   localparam int LANES   = 2;
   localparam int BASES   = 3;

   initial begin
      assert ((1 << SHIFT_W) == DATA_W)
         else $error("DATA_W must be a power of two");
      assert (CTRL_W <= DATA_W)
         else $error("control word does not fit in DATA_W");
      assert (FORCE_LSB + FORCE_W <= DATA_W)
         else $error("force field exceeds DATA_W");
   end

   logic [DATA_W-1:0]  acc_q   [LANES];
   logic [DATA_W-1:0]  base_q  [BASES];
   logic [SHIFT_W-1:0] shamt_q [LANES];
   logic [SHIFT_W-1:0] lo_q    [LANES];
   logic [SHIFT_W-1:0] hi_q    [LANES];
   lane_flags_t        flags_q [LANES];

   logic [DATA_W-1:0]  field_v  [LANES];
   logic [DATA_W-1:0]  lane_res [LANES];
   logic [DATA_W-1:0]  bus_res  [LANES];
   logic [DATA_W-1:0]  ctrl_rd  [LANES];
   lane_flags_t        wr_flags [LANES];
   logic               ovf      [LANES];
   logic [DATA_W-1:0]  full_res;
   logic               pop_req;
   logic               wr_req;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      interp_lane #(
         .DATA_W   (DATA_W),
         .SHIFT_W  (SHIFT_W),
         .CLAMP_EN (l == 0)
      ) u_lane (
         .own_acc   (acc_q[l]),
         .far_acc   (acc_q[LANES-1-l]),
         .base      (base_q[l]),
         .hi_bound  (base_q[1]),
         .shamt     (shamt_q[l]),
         .lo        (lo_q[l]),
         .hi        (hi_q[l]),
         .flags     (flags_q[l]),
         .field_val (field_v[l]),
         .result    (lane_res[l]),
         .ovf       (ovf[l])
      );

      // force bits reach the bus only
      assign bus_res[l] = lane_res[l]
                        | (DATA_W'(flags_q[l].force_hi) << FORCE_LSB);
      assign ctrl_rd[l] = DATA_W'({ovf[l], flags_q[l], hi_q[l], lo_q[l], shamt_q[l]});

      always_comb begin
         wr_flags[l] = lane_flags_t'(bus_wdata[OFF_FLG +: FLG_W]);
         wr_flags[l].clamp = wr_flags[l].clamp & (l == 0);
      end

      // R2: inverted range yields empty field
      a_r2_empty_field: assert property (@(posedge clk) disable iff (!rst_n)
         (hi_q[l] < lo_q[l]) |-> (field_v[l] == '0));
      // R10: a field reaching the top bit leaves nothing above it
      a_r10_no_ovf_at_top: assert property (@(posedge clk) disable iff (!rst_n)
         (hi_q[l] == '1) |-> !ovf[l]);
   end

   assign full_res = base_q[2] + field_v[0] + field_v[1];

   assign wr_req  = bus_sel && bus_wr;
   assign pop_req = bus_sel && !bus_wr &&
                    ((bus_addr == A_POP0) || (bus_addr == A_POP1) || (bus_addr == A_POPF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < LANES; l++) begin
            acc_q[l]   <= '0;
            shamt_q[l] <= '0;
            lo_q[l]    <= '0;
            hi_q[l]    <= '0;
            flags_q[l] <= '0;
         end
         for (int b = 0; b < BASES; b++) base_q[b] <= '0;
      end else if (wr_req) begin
         case (bus_addr)
            A_ACC0:  acc_q[0]  <= bus_wdata;
            A_ACC1:  acc_q[1]  <= bus_wdata;
            A_BASE0: base_q[0] <= bus_wdata;
            A_BASE1: base_q[1] <= bus_wdata;
            A_BASE2: base_q[2] <= bus_wdata;
            A_CTRL0: begin
               shamt_q[0] <= bus_wdata[0 +: SHIFT_W];
               lo_q[0]    <= bus_wdata[OFF_LO +: SHIFT_W];
               hi_q[0]    <= bus_wdata[OFF_HI +: SHIFT_W];
               flags_q[0] <= wr_flags[0];
            end
            A_CTRL1: begin
               shamt_q[1] <= bus_wdata[0 +: SHIFT_W];
               lo_q[1]    <= bus_wdata[OFF_LO +: SHIFT_W];
               hi_q[1]    <= bus_wdata[OFF_HI +: SHIFT_W];
               flags_q[1] <= wr_flags[1];
            end
            default: ;
         endcase
      end else if (pop_req) begin
         acc_q[0] <= flags_q[0].cross_res ? lane_res[1] : lane_res[0];
         acc_q[1] <= flags_q[1].cross_res ? lane_res[0] : lane_res[1];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            A_ACC0:          bus_rdata = acc_q[0];
            A_ACC1:          bus_rdata = acc_q[1];
            A_BASE0:         bus_rdata = base_q[0];
            A_BASE1:         bus_rdata = base_q[1];
            A_BASE2:         bus_rdata = base_q[2];
            A_CTRL0:         bus_rdata = ctrl_rd[0];
            A_CTRL1:         bus_rdata = ctrl_rd[1];
            A_PEEK0, A_POP0: bus_rdata = bus_res[0];
            A_PEEK1, A_POP1: bus_rdata = bus_res[1];
            A_PEEKF, A_POPF: bus_rdata = full_res;
            default:         bus_rdata = '0;
         endcase
      end
   end

   // R8: a pop without cross-result stores the lane's own result
   a_r8_pop_own_result: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !flags_q[0].cross_res) |=> (acc_q[0] == $past(lane_res[0])));
   // R8: reads other than pop leave the accumulators alone
   a_r8_peek_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !pop_req) |=> ($stable(acc_q[0]) && $stable(acc_q[1])));
   // R9: unsigned clamp with ordered bounds stays inside them
   a_r9_clamp_window: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[0].clamp && !flags_q[0].sgn && (base_q[0] <= base_q[1]))
      |-> ((lane_res[0] >= base_q[0]) && (lane_res[0] <= base_q[1])));

endmodule

// File: tb/interp_unit_tb.sv
module interp_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 10;

   typedef struct packed {
      logic [31:0] ctrl0, ctrl1, acc0, acc1, b0, b1, b2, e0, e1, ef;
   } vec_t;

   // ctrl: [4:0] shift [9:5] lo [14:10] hi 15 sgn 16 xin 17 xres 18 raw [20:19] force 21 clamp
   localparam vec_t VECS [NV] = '{
      // R2 shift 4 field 7:0 ; lane1 field bit 0
      '{32'h1C04, 32'h0000, 32'h12345678, 32'h3, 32'h100, 32'h10, 32'h1000, 32'h167, 32'h11, 32'h1068},
      // R3 signed lane0 ; R6 full uses sign-extended field
      '{32'h9C00, 32'h0C08, 32'hF0, 32'hABC, 32'h20, 32'h0, 32'h100, 32'h10, 32'hA, 32'hFA},
      // R2 mid field 11:4 ; lane1 inverted range gives zero
      '{32'h2C80, 32'h08A0, 32'hFFFF, 32'hFFFFFFFF, 32'h1, 32'h7, 32'h0, 32'hFF1, 32'h7, 32'hFF0},
      // R4 cross input with R5 raw add on lane0
      '{32'h50C04, 32'h1C00, 32'h55, 32'h1234, 32'h10, 32'h0, 32'h0, 32'h1244, 32'h34, 32'h37},
      // R7 force bits on bus
      '{32'h181C00, 32'h81C00, 32'h42, 32'h7, 32'h0, 32'h100, 32'h0, 32'h30000042, 32'h10000107, 32'h49},
      // R9 clamp unsigned below
      '{32'h201C00, 32'h1C00, 32'h05, 32'h2, 32'h10, 32'h40, 32'h0, 32'h10, 32'h42, 32'h7},
      // R9 clamp unsigned above
      '{32'h201C00, 32'h1C00, 32'hF0, 32'h2, 32'h10, 32'h40, 32'h0, 32'h40, 32'h42, 32'hF2},
      // R9 clamp in range
      '{32'h201C00, 32'h1C00, 32'h25, 32'h2, 32'h10, 32'h40, 32'h0, 32'h25, 32'h42, 32'h27},
      // R9 clamp signed
      '{32'h209C00, 32'h1C00, 32'hF0, 32'h2, 32'hFFFFFFF8, 32'h8, 32'h0, 32'hFFFFFFF8, 32'hA, 32'hFFFFFFF2},
      // R9 clamp bit on lane1 has no effect
      '{32'h1C00, 32'h201C00, 32'h1, 32'h80, 32'h0, 32'h4, 32'h0, 32'h1, 32'h84, 32'h81}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int fails  = 0;

   interp_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic load(input logic [31:0] c0, c1, a0, a1, b0, b1, b2);
      wr(4'd5, c0); wr(4'd6, c1);
      wr(4'd0, a0); wr(4'd1, a1);
      wr(4'd2, b0); wr(4'd3, b1); wr(4'd4, b2);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, d); check("R1 acc0 reset", d, 32'h0);
      rd(4'd4, d); check("R1 base2 reset", d, 32'h0);
      rd(4'd5, d); check("R1 ctrl0 reset", d, 32'h0);
      rd(4'd10, d); check("R1 full reset", d, 32'h0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         load(VECS[v].ctrl0, VECS[v].ctrl1, VECS[v].acc0, VECS[v].acc1,
              VECS[v].b0, VECS[v].b1, VECS[v].b2);
         rd(4'd8, d);  check($sformatf("table vec %0d lane0", v), d, VECS[v].e0);
         rd(4'd9, d);  check($sformatf("table vec %0d lane1", v), d, VECS[v].e1);
         rd(4'd10, d); check($sformatf("table vec %0d full", v), d, VECS[v].ef);
      end

      // R1 readback; R9 lane1 clamp bit not stored
      wr(4'd4, 32'hDEADBEEF); rd(4'd4, d); check("R1 base2 readback", d, 32'hDEADBEEF);
      wr(4'd1, 32'h0);
      wr(4'd6, 32'h3F9C04);   rd(4'd6, d); check("R9 ctrl1 clamp dropped", d, 32'h1F9C04);

      // R10 overflow flag
      load(32'h1C04, 32'h0, 32'h12345678, 32'h0, 32'h0, 32'h0, 32'h0);
      rd(4'd5, d); check("R10 overflow set", d, 32'h401C04);
      wr(4'd0, 32'h50);
      rd(4'd5, d); check("R10 overflow clear", d, 32'h1C04);

      // R8 peek has no side effect, pop loads both lanes
      load(32'h1C04, 32'h0, 32'h12345678, 32'h3, 32'h100, 32'h10, 32'h0);
      rd(4'd8, d);  check("R8 peek lane0", d, 32'h167);
      rd(4'd0, d);  check("R8 peek leaves acc0", d, 32'h12345678);
      rd(4'd12, d); check("R8 pop returns peek value", d, 32'h167);
      rd(4'd0, d);  check("R8 pop loads acc0", d, 32'h167);
      rd(4'd1, d);  check("R8 pop loads acc1", d, 32'h11);

      // R8 cross result
      load(32'h21C00, 32'h1C00, 32'h5, 32'h6, 32'h10, 32'h20, 32'h0);
      rd(4'd14, d); check("R8 pop full value", d, 32'hB);
      rd(4'd0, d);  check("R8 cross result acc0", d, 32'h26);
      rd(4'd1, d);  check("R8 own result acc1", d, 32'h26);

      // R7 force stays off the accumulator
      load(32'h181C00, 32'h0, 32'h42, 32'h0, 32'h0, 32'h0, 32'h0);
      rd(4'd12, d); check("R7 pop bus forced", d, 32'h30000042);
      rd(4'd0, d);  check("R7 acc0 unforced", d, 32'h42);

      // R5 raw add uses full input, full result uses field
      load(32'h40C04, 32'h0, 32'h1234, 32'h0, 32'h1, 32'h0, 32'h0);
      rd(4'd8, d);  check("R5 raw lane0", d, 32'h1235);
      rd(4'd10, d); check("R5 full uses field", d, 32'h3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule